// File: doc/BRIEF.md
# Transmit Deferral Timer

This block decides when a queued frame may begin transmission on a shared half-duplex Ethernet medium. It watches a carrier-sense input and runs an inter-packet gap timer in bit times. Each bit time is marked by a one-cycle tick enable, so the timer can run from any system clock faster than the bit rate. At 10 Mb/s the default gap of 96 ticks is 9.6 µs.

A mode pin selects one of two schemes. In two-part deferral, the first part of the gap (64 ticks by default) can be restarted: carrier seen during it resets the timer, and the timer starts again only once carrier drops. After that first part, the rest of the gap runs to expiry even if carrier comes back. In simple deferral, carrier seen anywhere in the gap restarts it.

The request and grant pins form a hold-until-taken handshake. `tx_req` plays the role of valid, `tx_permit` plays the role of ready, and `tx_start` is the transfer strobe. Once `tx_permit` rises it stays high until the transmitter pulses `tx_start`, even if the request drops or carrier returns in the meantime. The permit therefore cannot be withdrawn underneath the transmitter.

Top module: `tx_defer_timer`

## Requirements
- R1: After reset `tx_permit` is 0 and `deferring` is 1. A full gap must elapse before the first grant, even if carrier was never seen.
- R2: The gap starts on the first clock edge at which `carrier_sense` is sampled low while the medium is regarded as busy. The gap is satisfied on the edge that applies the GAP_BITS-th tick after that.
- R3: The gap count advances only on edges where `bit_tick` is 1. While `bit_tick` is 0, no amount of waiting satisfies the gap.
- R4: With `simple_defer` = 0 (two-part mode), carrier sampled while fewer than EARLY_BITS ticks of the gap have elapsed discards the gap. A new gap starts when carrier is next sampled low.
- R5: With `simple_defer` = 0, carrier sampled once EARLY_BITS or more ticks have elapsed is ignored, and the gap expires on schedule.
- R6: With `simple_defer` = 1 (simple mode), carrier sampled at any point before the gap is satisfied discards the gap. In the same cycle, carrier takes priority over a final tick.
- R7: `tx_permit` rises on the edge after the one that satisfies the gap, provided `tx_req` is 1 on that edge. While idle with the gap satisfied, it rises on the first edge at which `tx_req` is 1.
- R8: Once `tx_permit` is 1, it stays 1 regardless of `tx_req` and `carrier_sense` until an edge at which `tx_start` is 1. From that edge on, `tx_permit` is 0 and `deferring` is 1.
- R9: With the gap satisfied and no request pending, `deferring` is 0. Carrier sampled in that state makes `deferring` 1 again, and a new full gap is then needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle enable, once per bit time |
| carrier_sense | input | 1 | Medium activity seen |
| simple_defer | input | 1 | 0: two-part deferral, 1: simple deferral |
| tx_req | input | 1 | A frame is waiting to be sent |
| tx_start | input | 1 | Transmitter takes the grant this cycle |
| tx_permit | output | 1 | Transmission may begin; held until `tx_start` |
| deferring | output | 1 | Gap not yet satisfied |

## Verification
The bench builds the block with GAP_BITS = 12 and EARLY_BITS = 8. With these values a carrier pulse can be placed at every single position of the gap, in both modes, so the restart/commit boundary and the final-tick collision are each hit exactly. The grant time for each position is worked out arithmetically from the pulse position. A sparse tick pattern checks that timing counts ticks rather than clocks. The handshake is then driven through hold, release, idle and re-arming.

// File: rtl/tx_defer_pkg.sv
package tx_defer_pkg;
  typedef enum logic [2:0] {
    PH_BUSY,   // medium busy, waiting for carrier to drop
    PH_EARLY,  // restartable part of the gap
    PH_LATE,   // committed part (two-part) or still restartable (simple)
    PH_IDLE,   // gap satisfied, no request yet
    PH_GRANT   // permit held until the transmitter starts
  } defer_phase_e;
endpackage

// File: rtl/tx_defer_gap_counter.sv
module tx_defer_gap_counter #(
  parameter int GAP_BITS   = 96,
  parameter int EARLY_BITS = 64,
  localparam int CNT_W     = $clog2(GAP_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic early_last,
  output logic gap_last
);
  localparam logic [CNT_W-1:0] EARLY_LAST = CNT_W'(EARLY_BITS - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  assign early_last = (cnt_q == EARLY_LAST);
  assign gap_last   = (cnt_q == GAP_LAST);

  AST_CNT_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= GAP_LAST);                  // R2
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !adv) |=> $stable(cnt_q));  // R3
endmodule

// File: rtl/tx_defer_phase_fsm.sv
module tx_defer_phase_fsm
  import tx_defer_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         carrier_sense,
  input  logic         simple_defer,
  input  logic         tx_req,
  input  logic         tx_start,
  input  logic         early_last,
  input  logic         gap_last,
  output logic         cnt_clr,
  output logic         cnt_adv,
  output defer_phase_e phase
);
  defer_phase_e phase_d;
  logic         counting;
  logic         restart;

  assign counting = (phase == PH_EARLY) || (phase == PH_LATE);
  assign restart  = carrier_sense &&
                    ((phase == PH_EARLY) || ((phase == PH_LATE) && simple_defer));
  assign cnt_clr  = !counting || restart || (bit_tick && gap_last);
  assign cnt_adv  = bit_tick;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_BUSY:  if (!carrier_sense) phase_d = PH_EARLY;
      PH_EARLY: begin
        if (restart)                     phase_d = PH_BUSY;
        else if (bit_tick && gap_last)   phase_d = PH_IDLE;
        else if (bit_tick && early_last) phase_d = PH_LATE;
      end
      PH_LATE: begin
        if (restart)                     phase_d = PH_BUSY;
        else if (bit_tick && gap_last)   phase_d = PH_IDLE;
      end
      PH_IDLE: begin
        if (tx_req)                      phase_d = PH_GRANT;
        else if (carrier_sense)          phase_d = PH_BUSY;
      end
      PH_GRANT: if (tx_start)            phase_d = PH_BUSY;
      default:                           phase_d = PH_BUSY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_BUSY;
    else        phase <= phase_d;
  end

  AST_EARLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EARLY && carrier_sense) |=> (phase == PH_BUSY));                             // R4
  AST_LATE_COMMIT:   assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LATE && !simple_defer) |=> (phase == PH_LATE || phase == PH_IDLE));          // R5
  AST_SIMPLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LATE && simple_defer && carrier_sense) |=> (phase == PH_BUSY));              // R6
  AST_IDLE_REARM:    assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !tx_req && carrier_sense) |=> (phase == PH_BUSY));                   // R9
endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer
  import tx_defer_pkg::*;
#(
  parameter int GAP_BITS   = 96,
  parameter int EARLY_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic carrier_sense,
  input  logic simple_defer,
  input  logic tx_req,
  input  logic tx_start,
  output logic tx_permit,
  output logic deferring
);
  logic         cnt_clr, cnt_adv, early_last, gap_last;
  defer_phase_e phase;

  tx_defer_gap_counter #(.GAP_BITS(GAP_BITS), .EARLY_BITS(EARLY_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(cnt_adv),
    .early_last(early_last), .gap_last(gap_last)
  );

  tx_defer_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
    .simple_defer(simple_defer), .tx_req(tx_req), .tx_start(tx_start),
    .early_last(early_last), .gap_last(gap_last),
    .cnt_clr(cnt_clr), .cnt_adv(cnt_adv), .phase(phase)
  );

  assign tx_permit = (phase == PH_GRANT);
  assign deferring = (phase == PH_BUSY) || (phase == PH_EARLY) || (phase == PH_LATE);

  initial begin
    assert (EARLY_BITS > 0 && EARLY_BITS < GAP_BITS);  // R4
  end

  AST_PERMIT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && !tx_start) |=> tx_permit);                 // R8
  AST_START_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n)
    (tx_permit && tx_start) |=> (!tx_permit && deferring));  // R8
  AST_GRANT_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> !$past(deferring));                 // R7
endmodule

// File: tb/tx_defer_timer_tb_top.sv
module tx_defer_timer_tb_top;
  localparam int G = 12;
  localparam int E = 8;

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, carrier_sense = 1, simple_defer = 0, tx_req = 0, tx_start = 0;
  logic tx_permit, deferring;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  tx_defer_timer #(.GAP_BITS(G), .EARLY_BITS(E)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier_sense(carrier_sense),
    .simple_defer(simple_defer), .tx_req(tx_req), .tx_start(tx_start),
    .tx_permit(tx_permit), .deferring(deferring)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; carrier_sense = 1; tx_req = 1; tx_start = 0; bit_tick = 1;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Drop carrier, optionally pulse it before edge p, return edge count of first grant.
  // tick_div: bit_tick high on edges c with c % tick_div == 0 (1 = every edge).
  task automatic run_gap(input int p, input int tick_div, output int n);
    n = -1;
    carrier_sense = 0;
    bit_tick = (tick_div == 1) || ((1 % tick_div) == 0);
    for (int c = 1; c <= 200; c++) begin
      @(posedge clk); @(negedge clk);
      if (tx_permit && n < 0) n = c;
      carrier_sense = (c + 1 == p);
      bit_tick = (tick_div == 1) || (((c + 1) % tick_div) == 0);
    end
    bit_tick = 1;
  endtask

  initial begin
    int n;
    do_reset();
    // R1: reset state (carrier still high)
    check("R1 permit after reset", tx_permit, 0);
    check("R1 deferring after reset", deferring, 1);

    // R1/R2/R7: clean gap in both modes
    for (int m = 0; m < 2; m++) begin
      simple_defer = m[0];
      do_reset();
      run_gap(0, 1, n);
      check(m ? "R2 R7 clean gap simple" : "R1 R2 R7 clean gap two-part", n, G + 2);
    end

    // R4/R5/R6: carrier pulse at every gap position
    for (int m = 0; m < 2; m++) begin
      for (int p = 2; p <= G + 1; p++) begin
        bit restart;
        simple_defer = m[0];
        restart = m[0] || (p <= E + 1);
        do_reset();
        run_gap(p, 1, n);
        if (m == 1)          check("R6 simple pulse", n, p + G + 2);
        else if (restart)    check("R4 early pulse", n, p + G + 2);
        else                 check("R5 late pulse ignored", n, G + 2);
      end
    end

    // R3: ticks every third edge
    simple_defer = 0;
    do_reset();
    run_gap(0, 3, n);
    check("R3 sparse ticks", n, 3 * G + 1);

    // R3: no ticks, no progress
    do_reset();
    carrier_sense = 0; bit_tick = 0;
    repeat (3 * G) @(negedge clk);
    check("R3 no tick permit", tx_permit, 0);
    check("R3 no tick deferring", deferring, 1);

    // R8: hold permit despite request drop and carrier
    bit_tick = 1;
    repeat (G + 2) @(negedge clk);
    check("R7 permit after ticks resume", tx_permit, 1);
    tx_req = 0; carrier_sense = 1;
    repeat (5) @(negedge clk);
    check("R8 permit held", tx_permit, 1);
    tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    check("R8 permit released", tx_permit, 0);
    check("R8 deferring after start", deferring, 1);

    // R9: idle without request, then carrier re-arms
    carrier_sense = 0;
    repeat (G + 1) @(negedge clk);
    check("R9 idle deferring", deferring, 0);
    check("R9 idle permit", tx_permit, 0);
    carrier_sense = 1;
    @(negedge clk);
    check("R9 carrier re-arms", deferring, 1);
    carrier_sense = 0; tx_req = 1;
    repeat (G + 1) @(negedge clk);
    check("R9 full gap needed", tx_permit, 0);
    @(negedge clk);
    check("R7 grant after new gap", tx_permit, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule